// File: doc/BRIEF.md
# Output-Channel Group Scheduler

This block plans how the output channels of one convolution layer are spread over a small, fixed set of compute cores. Software first loads a layer description: kernel height, kernel width, weight format and output channel count. A start pulse then begins a job. From the loaded description the block works out how many channels each core may hold in one pass. That number, the group size, is limited by two things: the per-core accumulator budget, shared out among the kernel elements, and a byte budget set by the weight format.

During a job the block emits one assignment per output channel on a valid/ready stream, in ascending channel order. Each assignment gives the channel, the core that serves it, the pass it belongs to and its lane inside that core's group. Channels are striped over the cores, so channel c goes to core c mod 4. A core's power-enable is raised for the whole job only if at least one channel lands on that core. A one-cycle done pulse closes each job.

Top module: `ocg_scheduler`

## Requirements
- R1: With k = kh*kw, where a kernel dimension of 0 counts as 1, the group size (`grp_size`) is the largest power of two G with G*k <= 8. G is 1 when k exceeds 8.
- R2: The group size is further capped at (byte budget / 4). The byte budget is 32 for format code 0, 16 for code 1 and 8 for codes 2 and 3, which gives caps of 8, 4 and 2 channels.
- R3: A job with N > 0 channels emits channels 0 to N-1 in ascending order, each exactly once, with `asg_core` = channel mod 4. The first assignment is valid in the cycle after the start pulse is sampled.
- R4: Each assignment carries `asg_pass` = floor(c / (4*G)) and `asg_lane` = floor(c / 4) mod G. `num_passes` = ceil(ceil(N/4) / G).
- R5: While a job is busy, bit i of `pwr_en` is 1 exactly when N > i, so a core is powered only if at least one channel is striped onto it. All bits are 0 when idle.
- R6: While `asg_valid` is high and `asg_ready` is low, the assignment fields hold their values. A transfer takes place on each clock edge where both are high.
- R7: `done` is high for exactly one cycle, the cycle after the last transfer. With N = 0, `done` is high in the cycle after the start pulse and no assignment is emitted.
- R8: A configuration load or start pulse presented while busy is ignored. The running job is unchanged, and a later start uses the configuration from the last load made while idle.
- R9: During reset `asg_valid`, `busy`, `done` and `pwr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_load | input | 1 | Capture the layer description (only when idle) |
| cfg_kh | input | 4 | Kernel height (0 treated as 1) |
| cfg_kw | input | 4 | Kernel width (0 treated as 1) |
| cfg_fmt | input | 2 | Weight format code: 0, 1, 2 or 3 |
| cfg_nch | input | 10 | Output channel count |
| start | input | 1 | Begin a job with the held description (only when idle) |
| asg_valid | output | 1 | Assignment on the stream is valid |
| asg_ready | input | 1 | Consumer accepts the assignment |
| asg_chan | output | 10 | Output channel index |
| asg_core | output | 2 | Core serving the channel |
| asg_pass | output | 10 | Pass number |
| asg_lane | output | 4 | Lane in the core's group for this pass |
| grp_size | output | 4 | Group size of the current or last job |
| num_passes | output | 10 | Pass count of the current or last job |
| pwr_en | output | 4 | Per-core power-domain enables |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
Directed layers cover each regime of the group-size rule separately. A 1x1 kernel with the widest format makes the accumulator term give 8. Kernels of 3 and 2 elements give 2 and 4. A 3x3 kernel goes over the budget, and zero dimensions must count as 1. Narrower formats isolate the byte cap from the accumulator term. Channel counts of 0, 1, 3, 4, 9 and 1023 test the power mask below and at the core count, the pass boundaries and the empty job. Random layers run with random ready stalls to exercise payload holding. A busy-time reload followed by an unloaded restart shows whether busy-time configuration leaks into the held description.

// File: rtl/ocg_sched_pkg.sv
package ocg_sched_pkg;

  typedef enum logic [1:0] {
    WFMT_BYTE  = 2'd0,
    WFMT_HALF  = 2'd1,
    WFMT_WORD  = 2'd2,
    WFMT_SPARE = 2'd3
  } wfmt_e;

  // Byte budget per element granted to each weight format.
  function automatic int fmt_byte_budget(input wfmt_e f);
    case (f)
      WFMT_BYTE: return 32;
      WFMT_HALF: return 16;
      default:   return 8;
    endcase
  endfunction

  // log2 of the largest power of two not above bytes/ch_bytes (0 if below 1).
  function automatic int cap_log2(input int bytes, input int ch_bytes);
    int cap;
    int l;
    cap = bytes / ch_bytes;
    l   = 0;
    for (int i = 0; i < 16; i++) begin
      if ((2 << l) <= cap) l = l + 1;
    end
    return l;
  endfunction

endpackage

// File: rtl/ocg_rst_sync.sv
module ocg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/ocg_group_calc.sv
module ocg_group_calc
  import ocg_sched_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int ACC_BUDGET = 8,
  parameter int CH_BYTES   = 4,
  parameter int KDIM_W     = 4,
  parameter int CH_W       = 10,
  parameter int EXP_W      = 3
) (
  input  logic [KDIM_W-1:0] kh,
  input  logic [KDIM_W-1:0] kw,
  input  logic [1:0]        fmt,
  input  logic [CH_W-1:0]   nch,
  output logic [EXP_W-1:0]  grp_log2,
  output logic [CH_W-1:0]   passes
);

  localparam int EMAX   = $clog2(ACC_BUDGET);
  localparam int CORE_W = $clog2(NUM_CORES);
  localparam int KEL_W  = 2 * KDIM_W;
  localparam int PROD_W = KEL_W + EMAX + 1;

  logic [KDIM_W-1:0] kh_eff;
  logic [KDIM_W-1:0] kw_eff;
  logic [KEL_W-1:0]  kel;
  logic [EMAX:0]     fits;

  assign kh_eff = (kh == '0) ? KDIM_W'(1) : kh;
  assign kw_eff = (kw == '0) ? KDIM_W'(1) : kw;
  assign kel    = KEL_W'(kh_eff) * KEL_W'(kw_eff);

  // One comparator per candidate exponent: does 2^e * k stay in budget?
  for (genvar e = 0; e <= EMAX; e++) begin : g_fit
    assign fits[e] = ((PROD_W'(kel) << e) <= PROD_W'(ACC_BUDGET));
  end

  always_comb begin
    int fit_l;
    int cap_l;
    fit_l = 0;
    for (int e = 0; e <= EMAX; e++) begin
      if (fits[e]) fit_l = e;
    end
    cap_l = cap_log2(fmt_byte_budget(wfmt_e'(fmt)), CH_BYTES);
    grp_log2 = (cap_l < fit_l) ? EXP_W'(cap_l) : EXP_W'(fit_l);
  end

  logic [CH_W:0] lanes;
  logic [CH_W:0] gm1;
  logic [CH_W:0] pas;

  always_comb begin
    lanes  = ({1'b0, nch} + (CH_W+1)'(NUM_CORES - 1)) >> CORE_W;
    gm1    = ((CH_W+1)'(1) << grp_log2) - (CH_W+1)'(1);
    pas    = (lanes + gm1) >> grp_log2;
    passes = pas[CH_W-1:0];
  end

endmodule

// File: rtl/ocg_chan_walker.sv
module ocg_chan_walker #(
  parameter int NUM_CORES = 4,
  parameter int CH_W      = 10,
  parameter int EXP_W     = 3,
  parameter int LANE_W    = 4,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ready,
  input  logic [EXP_W-1:0]  in_log2,
  input  logic [CH_W-1:0]   in_nch,
  input  logic [CH_W-1:0]   in_passes,
  output logic              busy,
  output logic              done,
  output logic [CH_W-1:0]   chan,
  output logic [CORE_W-1:0] core,
  output logic [LANE_W-1:0] lane,
  output logic [CH_W-1:0]   pass,
  output logic [EXP_W-1:0]  plan_log2,
  output logic [CH_W-1:0]   plan_nch,
  output logic [CH_W-1:0]   plan_passes
);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic [CORE_W-1:0] core_q, core_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [CH_W-1:0]   pass_q, pass_d;
  logic [EXP_W-1:0]  log2_q, log2_d;
  logic [CH_W-1:0]   nch_q, nch_d;
  logic [CH_W-1:0]   npas_q, npas_d;
  logic [LANE_W-1:0] lane_max;
  logic              launch;
  logic              advance;

  assign lane_max = (LANE_W'(1) << log2_q) - LANE_W'(1);
  assign launch   = !busy_q && start;
  assign advance  = busy_q && ready;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    chan_d = chan_q;
    core_d = core_q;
    lane_d = lane_q;
    pass_d = pass_q;
    log2_d = log2_q;
    nch_d  = nch_q;
    npas_d = npas_q;
    if (launch) begin
      log2_d = in_log2;
      nch_d  = in_nch;
      npas_d = in_passes;
      chan_d = '0;
      core_d = '0;
      lane_d = '0;
      pass_d = '0;
      if (in_nch == '0) done_d = 1'b1;
      else              busy_d = 1'b1;
    end else if (advance) begin
      if (chan_q == nch_q - CH_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        chan_d = chan_q + CH_W'(1);
        if (core_q == CORE_W'(NUM_CORES - 1)) begin
          core_d = '0;
          if (lane_q == lane_max) begin
            lane_d = '0;
            pass_d = pass_q + CH_W'(1);
          end else begin
            lane_d = lane_q + LANE_W'(1);
          end
        end else begin
          core_d = core_q + CORE_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      chan_q <= '0;
      core_q <= '0;
      lane_q <= '0;
      pass_q <= '0;
      log2_q <= '0;
      nch_q  <= '0;
      npas_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (launch || advance) begin
        chan_q <= chan_d;
        core_q <= core_d;
        lane_q <= lane_d;
        pass_q <= pass_d;
      end
      if (launch) begin
        log2_q <= log2_d;
        nch_q  <= nch_d;
        npas_q <= npas_d;
      end
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign chan        = chan_q;
  assign core        = core_q;
  assign lane        = lane_q;
  assign pass        = pass_q;
  assign plan_log2   = log2_q;
  assign plan_nch    = nch_q;
  assign plan_passes = npas_q;

endmodule

// File: rtl/ocg_power_mask.sv
module ocg_power_mask #(
  parameter int NUM_CORES = 4,
  parameter int CH_W      = 10
) (
  input  logic                 busy,
  input  logic [CH_W-1:0]      nch,
  output logic [NUM_CORES-1:0] en
);

  // Core i carries a channel exactly when the count reaches past index i.
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_dom
    assign en[i] = busy && (nch > CH_W'(i));
  end

endmodule

// File: rtl/ocg_scheduler.sv
module ocg_scheduler #(
  parameter int NUM_CORES  = 4,
  parameter int ACC_BUDGET = 8,
  parameter int CH_BYTES   = 4,
  parameter int KDIM_W     = 4,
  parameter int CH_W       = 10,
  localparam int CORE_W    = $clog2(NUM_CORES),
  localparam int EMAX      = $clog2(ACC_BUDGET),
  localparam int EXP_W     = $clog2(EMAX + 2),
  localparam int GS_W      = EMAX + 1,
  localparam int LANE_W    = EMAX + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic [KDIM_W-1:0]    cfg_kh,
  input  logic [KDIM_W-1:0]    cfg_kw,
  input  logic [1:0]           cfg_fmt,
  input  logic [CH_W-1:0]      cfg_nch,
  input  logic                 start,
  output logic                 asg_valid,
  input  logic                 asg_ready,
  output logic [CH_W-1:0]      asg_chan,
  output logic [CORE_W-1:0]    asg_core,
  output logic [CH_W-1:0]      asg_pass,
  output logic [LANE_W-1:0]    asg_lane,
  output logic [GS_W-1:0]      grp_size,
  output logic [CH_W-1:0]      num_passes,
  output logic [NUM_CORES-1:0] pwr_en,
  output logic                 busy,
  output logic                 done
);

  logic rst_n_sync;

  ocg_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // Held layer description, captured only while idle.
  logic [KDIM_W-1:0] kh_q, kh_d;
  logic [KDIM_W-1:0] kw_q, kw_d;
  logic [1:0]        fmt_q, fmt_d;
  logic [CH_W-1:0]   nch_q, nch_d;
  logic              cfg_en;
  logic              busy_w;

  assign cfg_en = cfg_load && !busy_w;

  always_comb begin
    kh_d  = cfg_en ? cfg_kh  : kh_q;
    kw_d  = cfg_en ? cfg_kw  : kw_q;
    fmt_d = cfg_en ? cfg_fmt : fmt_q;
    nch_d = cfg_en ? cfg_nch : nch_q;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      kh_q  <= '0;
      kw_q  <= '0;
      fmt_q <= '0;
      nch_q <= '0;
    end else if (cfg_en) begin
      kh_q  <= kh_d;
      kw_q  <= kw_d;
      fmt_q <= fmt_d;
      nch_q <= nch_d;
    end
  end

  logic [EXP_W-1:0] calc_log2;
  logic [CH_W-1:0]  calc_passes;

  ocg_group_calc #(
    .NUM_CORES  (NUM_CORES),
    .ACC_BUDGET (ACC_BUDGET),
    .CH_BYTES   (CH_BYTES),
    .KDIM_W     (KDIM_W),
    .CH_W       (CH_W),
    .EXP_W      (EXP_W)
  ) u_calc (
    .kh       (kh_q),
    .kw       (kw_q),
    .fmt      (fmt_q),
    .nch      (nch_q),
    .grp_log2 (calc_log2),
    .passes   (calc_passes)
  );

  logic [EXP_W-1:0] plan_log2;
  logic [CH_W-1:0]  plan_nch;
  logic [CH_W-1:0]  plan_passes;

  ocg_chan_walker #(
    .NUM_CORES (NUM_CORES),
    .CH_W      (CH_W),
    .EXP_W     (EXP_W),
    .LANE_W    (LANE_W)
  ) u_walk (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .start       (start),
    .ready       (asg_ready),
    .in_log2     (calc_log2),
    .in_nch      (nch_q),
    .in_passes   (calc_passes),
    .busy        (busy_w),
    .done        (done),
    .chan        (asg_chan),
    .core        (asg_core),
    .lane        (asg_lane),
    .pass        (asg_pass),
    .plan_log2   (plan_log2),
    .plan_nch    (plan_nch),
    .plan_passes (plan_passes)
  );

  ocg_power_mask #(
    .NUM_CORES (NUM_CORES),
    .CH_W      (CH_W)
  ) u_pwr (
    .busy (busy_w),
    .nch  (plan_nch),
    .en   (pwr_en)
  );

  assign busy       = busy_w;
  assign asg_valid  = busy_w;
  assign grp_size   = GS_W'(1) << plan_log2;
  assign num_passes = plan_passes;

endmodule

// File: rtl/ocg_sched_checker.sv
module ocg_sched_checker #(
  parameter int NUM_CORES = 4,
  parameter int CH_W      = 10,
  parameter int CORE_W    = 2,
  parameter int GS_W      = 4,
  parameter int LANE_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 asg_valid,
  input logic                 asg_ready,
  input logic [CH_W-1:0]      asg_chan,
  input logic [CORE_W-1:0]    asg_core,
  input logic [CH_W-1:0]      asg_pass,
  input logic [LANE_W-1:0]    asg_lane,
  input logic [GS_W-1:0]      grp_size,
  input logic [CH_W-1:0]      num_passes,
  input logic [NUM_CORES-1:0] pwr_en,
  input logic                 busy,
  input logic                 done
);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid && !asg_ready |=> asg_valid && $stable(asg_chan) && $stable(asg_core)
                                && $stable(asg_pass) && $stable(asg_lane));

  assert_stripe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid |-> asg_core == asg_chan[CORE_W-1:0]);

  assert_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid && asg_ready |=> !asg_valid || (32'(asg_chan) == 32'($past(asg_chan)) + 1));

  assert_core_powered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid |-> pwr_en[asg_core]);

  assert_idle_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> pwr_en == '0);

  assert_pass_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid |-> asg_pass < num_passes);

  assert_lane_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    asg_valid |-> 32'(asg_lane) < 32'(grp_size));

  assert_group_pow2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(grp_size) == 1);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !asg_valid);

endmodule

bind ocg_scheduler ocg_sched_checker #(
  .NUM_CORES (NUM_CORES),
  .CH_W      (CH_W),
  .CORE_W    (CORE_W),
  .GS_W      (GS_W),
  .LANE_W    (LANE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .asg_valid  (asg_valid),
  .asg_ready  (asg_ready),
  .asg_chan   (asg_chan),
  .asg_core   (asg_core),
  .asg_pass   (asg_pass),
  .asg_lane   (asg_lane),
  .grp_size   (grp_size),
  .num_passes (num_passes),
  .pwr_en     (pwr_en),
  .busy       (busy),
  .done       (done)
);

// File: tb/ocg_scheduler_bench.sv
`timescale 1ns/1ps
module ocg_scheduler_bench;

  logic       clk;
  logic       rst_n;
  logic       cfg_load;
  logic [3:0] cfg_kh;
  logic [3:0] cfg_kw;
  logic [1:0] cfg_fmt;
  logic [9:0] cfg_nch;
  logic       start;
  logic       asg_valid;
  logic       asg_ready;
  logic [9:0] asg_chan;
  logic [1:0] asg_core;
  logic [9:0] asg_pass;
  logic [3:0] asg_lane;
  logic [3:0] grp_size;
  logic [9:0] num_passes;
  logic [3:0] pwr_en;
  logic       busy;
  logic       done;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  ocg_scheduler u_ocg_scheduler (
    .clk (clk), .rst_n (rst_n), .cfg_load (cfg_load), .cfg_kh (cfg_kh),
    .cfg_kw (cfg_kw), .cfg_fmt (cfg_fmt), .cfg_nch (cfg_nch), .start (start),
    .asg_valid (asg_valid), .asg_ready (asg_ready), .asg_chan (asg_chan),
    .asg_core (asg_core), .asg_pass (asg_pass), .asg_lane (asg_lane),
    .grp_size (grp_size), .num_passes (num_passes), .pwr_en (pwr_en),
    .busy (busy), .done (done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_group(input int kh, input int kw, input int fmt);
    int k, g, cap;
    k = ((kh == 0) ? 1 : kh) * ((kw == 0) ? 1 : kw);
    g = 1;
    while (g * 2 * k <= 8) g = g * 2;
    cap = (fmt == 0) ? 8 : (fmt == 1) ? 4 : 2;
    return (g < cap) ? g : cap;
  endfunction

  function automatic int exp_passes(input int n, input int g);
    int lanes;
    lanes = (n + 3) / 4;
    return (lanes + g - 1) / g;
  endfunction

  function automatic int exp_mask(input int n);
    return (n >= 4) ? 15 : ((1 << n) - 1);
  endfunction

  task automatic load_cfg(input int kh, input int kw, input int fmt, input int nch);
    cfg_kh   = 4'(kh);
    cfg_kw   = 4'(kw);
    cfg_fmt  = 2'(fmt);
    cfg_nch  = 10'(nch);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // Runs one job; called and returns at a falling edge.
  task automatic run_job(input int kh, input int kw, input int fmt, input int nch,
                         input bit inject, input bit do_load);
    int g, p, c, cyc;
    bit stall;
    g = exp_group(kh, kw, fmt);
    p = exp_passes(nch, g);
    if (do_load) load_cfg(kh, kw, fmt, nch);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (nch == 0) begin
      check_eq("R7", "empty job done", int'(done), 1);
      check_eq("R7", "empty job valid", int'(asg_valid), 0);
      check_eq("R5", "empty job pwr_en", int'(pwr_en), 0);
      @(negedge clk);
      check_eq("R7", "empty job done width", int'(done), 0);
      return;
    end
    check_eq("R3", "valid after start", int'(asg_valid), 1);
    check_eq("R1 R2", "grp_size", int'(grp_size), g);
    check_eq("R4", "num_passes", int'(num_passes), p);
    c = 0;
    cyc = 0;
    stall = 1'b0;
    while (c < nch && cyc < nch * 8 + 50) begin
      check_eq("R5", "pwr_en", int'(pwr_en), exp_mask(nch));
      if (stall) check_eq("R6", "held chan", int'(asg_chan), c);
      asg_ready = ($urandom % 4) != 0;
      if (inject && cyc == 1) begin
        cfg_kh = 4'd1; cfg_kw = 4'd1; cfg_fmt = 2'd0; cfg_nch = 10'(nch + 7);
        cfg_load = 1'b1;
        start = 1'b1;
      end
      stall = 1'b0;
      if (asg_valid && asg_ready) begin
        check_eq("R3", "chan", int'(asg_chan), c);
        check_eq("R3", "core", int'(asg_core), c % 4);
        check_eq("R4", "pass", int'(asg_pass), c / (4 * g));
        check_eq("R4", "lane", int'(asg_lane), (c / 4) % g);
        c++;
      end else if (asg_valid) begin
        stall = 1'b1;
      end
      @(negedge clk);
      cfg_load = 1'b0;
      start    = 1'b0;
      cyc++;
    end
    asg_ready = 1'b0;
    check_eq("R3", "transfers", c, nch);
    check_eq("R7", "done after last", int'(done), 1);
    check_eq("R7", "valid at done", int'(asg_valid), 0);
    @(negedge clk);
    check_eq("R7", "done one cycle", int'(done), 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h00c0_ffee);
    rst_n = 1'b0;
    cfg_load = 1'b0; start = 1'b0; asg_ready = 1'b0;
    cfg_kh = '0; cfg_kw = '0; cfg_fmt = '0; cfg_nch = '0;
    repeat (3) @(negedge clk);
    check_eq("R9", "reset valid", int'(asg_valid), 0);
    check_eq("R9", "reset busy", int'(busy), 0);
    check_eq("R9", "reset done", int'(done), 0);
    check_eq("R9", "reset pwr_en", int'(pwr_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_job(1, 1, 0, 1, 1'b0, 1'b1);      // R1 G=8, R5 single core
    run_job(3, 3, 0, 20, 1'b0, 1'b1);     // R1 over budget, G=1
    run_job(1, 1, 2, 9, 1'b0, 1'b1);      // R2 cap 2
    run_job(2, 1, 1, 4, 1'b0, 1'b1);      // R2 cap 4 meets G=4
    run_job(1, 3, 0, 6, 1'b0, 1'b1);      // R1 k=3 gives 2
    run_job(0, 0, 3, 3, 1'b0, 1'b1);      // R1 zero dims, R2 spare code
    run_job(2, 2, 0, 0, 1'b0, 1'b1);      // R7 empty job
    run_job(1, 1, 0, 40, 1'b1, 1'b1);     // R8 busy reload injected
    run_job(1, 1, 0, 40, 1'b0, 1'b0);     // R8 restart uses idle-time config
    run_job(3, 3, 1, 1023, 1'b0, 1'b1);   // R4 many passes

    for (int i = 0; i < 24; i++) begin
      run_job(int'($urandom % 5), int'($urandom % 5), int'($urandom % 4),
              int'($urandom % 81), 1'b0, 1'b1);
    end

    summary();
    $finish;
  end

endmodule